// File: doc/BRIEF.md
# Shared-Adder Signed Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit for two signed operands of 16 bits. A 3-bit operation code picks one of eight functions: add with a carry input, add one operand to half of the other, increment, scale by one and a half, bitwise AND, bitwise OR, bitwise inversion, and a no-operation code. Each function produces a 16-bit result together with a zero flag and a negative flag.

All four arithmetic functions go through a single adder. Halving is done as an arithmetic right shift by one bit, so scaling by one and a half becomes the operand plus the operand shifted right. An operand multiplexer in front of the adder picks the second adder input and the adder's carry input from the operation code. Results wrap modulo 2^16. The block has no overflow output and no carry-out output. The adder can be built either as a behavioural sum or as an explicit ripple chain, chosen by a parameter.

Top module: `alu16_shared`

## Requirements
- R1: Code 3'b000 gives res_o = m_i + n_i + cin_i, truncated to 16 bits (wraps modulo 2^16).
- R2: Code 3'b001 gives res_o = m_i + floor(n_i / 2), where n_i is read as signed and halving rounds toward negative infinity (n_i = -1 halves to -1, n_i = -3 halves to -2). The sum wraps to 16 bits.
- R3: Code 3'b010 gives res_o = m_i + 1, wrapping 16'hFFFF to 16'h0000.
- R4: Code 3'b011 gives res_o = m_i + floor(m_i / 2), where m_i is read as signed. The sum wraps to 16 bits.
- R5: Codes 3'b100, 3'b101 and 3'b110 give m_i AND n_i, m_i OR n_i, and NOT m_i respectively. Code 3'b110 does not depend on n_i.
- R6: Code 3'b111 gives res_o = 16'h0000 whatever the other inputs are.
- R7: zero_o is 1 exactly when res_o is 16'h0000, for every code.
- R8: neg_o equals bit 15 of res_o, for every code.
- R9: cin_i affects the result only under code 3'b000. Under every other code, changing cin_i leaves res_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| m_i | input | 16 | First signed operand |
| n_i | input | 16 | Second signed operand |
| cin_i | input | 1 | Carry input, used only for add with carry |
| op_i | input | 3 | Operation code |
| res_o | output | 16 | Result |
| zero_o | output | 1 | Result equals zero |
| neg_o | output | 1 | Bit 15 of the result |

## Verification
All three outputs are combinational, so every result is due in the same cycle as its stimulus, with no register between input and output. The driver applies a stimulus just after a rising clock edge and pushes the expected result into a queue. The monitor pops that item half a cycle later, at the falling edge, and compares it with the outputs once they have settled. The queue therefore holds at most one item, and each comparison is made against the stimulus of the same cycle. For R9, the same operands are applied twice with opposite carry inputs, so any dependence on cin_i shows up as a result change.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [2:0] {
    OP_ADDC = 3'b000,
    OP_ADDH = 3'b001,
    OP_INC  = 3'b010,
    OP_X15  = 3'b011,
    OP_AND  = 3'b100,
    OP_OR   = 3'b101,
    OP_NOT  = 3'b110,
    OP_NOP  = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    BSEL_N     = 2'd0,
    BSEL_NHALF = 2'd1,
    BSEL_ZERO  = 2'd2,
    BSEL_MHALF = 2'd3
  } bsel_e;

  typedef enum logic [1:0] {
    CSEL_EXT  = 2'd0,
    CSEL_ZERO = 2'd1,
    CSEL_ONE  = 2'd2
  } csel_e;

endpackage

// File: rtl/alu16_operand_mux.sv
module alu16_operand_mux
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   m,
  input  logic [W-1:0]   n,
  input  logic           cin,
  output logic [W-1:0]   add_b,
  output logic           add_ci,
  output logic           is_arith
);

  // arithmetic shift right by one: floor division by two
  function automatic logic [W-1:0] asr1(input logic [W-1:0] v);
    return {v[W-1], v[W-1:1]};
  endfunction

  bsel_e bsel;
  csel_e csel;

  always_comb begin
    bsel     = BSEL_ZERO;
    csel     = CSEL_ZERO;
    is_arith = 1'b0;
    unique case (op)
      OP_ADDC: begin bsel = BSEL_N;     csel = CSEL_EXT;  is_arith = 1'b1; end
      OP_ADDH: begin bsel = BSEL_NHALF; csel = CSEL_ZERO; is_arith = 1'b1; end
      OP_INC:  begin bsel = BSEL_ZERO;  csel = CSEL_ONE;  is_arith = 1'b1; end
      OP_X15:  begin bsel = BSEL_MHALF; csel = CSEL_ZERO; is_arith = 1'b1; end
      default: begin bsel = BSEL_ZERO;  csel = CSEL_ZERO; is_arith = 1'b0; end
    endcase
  end

  always_comb begin
    unique case (bsel)
      BSEL_N:     add_b = n;
      BSEL_NHALF: add_b = asr1(n);
      BSEL_MHALF: add_b = asr1(m);
      default:    add_b = '0;
    endcase
  end

  always_comb begin
    unique case (csel)
      CSEL_EXT: add_ci = cin;
      CSEL_ONE: add_ci = 1'b1;
      default:  add_ci = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu16_shared_adder.sv
module alu16_shared_adder #(
  parameter int W      = 16,
  parameter bit RIPPLE = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] sum
);

  // wrapping sum, carry-out discarded
  function automatic logic [W-1:0] add_wrap(input logic [W-1:0] x,
                                            input logic [W-1:0] y,
                                            input logic         c);
    logic [W:0] t;
    t = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    return t[W-1:0];
  endfunction

  generate
    if (RIPPLE) begin : g_ripple
      logic [W-1:0] carry;
      for (genvar i = 0; i < W; i++) begin : g_bit
        logic cprev;
        if (i == 0) begin : g_first
          assign cprev = ci;
        end else begin : g_rest
          assign cprev = carry[i-1];
        end
        assign sum[i]   = a[i] ^ b[i] ^ cprev;
        assign carry[i] = (a[i] & b[i]) | (cprev & (a[i] ^ b[i]));
      end
    end else begin : g_behav
      assign sum = add_wrap(a, b, ci);
    end
  endgenerate

endmodule

// File: rtl/alu16_logic_unit.sv
module alu16_logic_unit
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] m,
  input  logic [W-1:0] n,
  output logic [W-1:0] out
);

  always_comb begin
    unique case (op)
      OP_AND:  out = m & n;
      OP_OR:   out = m | n;
      OP_NOT:  out = ~m;
      default: out = '0;
    endcase
  end

endmodule

// File: rtl/alu16_flag_gen.sv
module alu16_flag_gen #(
  parameter int W = 16
) (
  input  logic [W-1:0] res,
  output logic         zero,
  output logic         neg
);

  assign zero = ~|res;
  assign neg  = res[W-1];

endmodule

// File: rtl/alu16_shared.sv
module alu16_shared
  import alu16_pkg::*;
#(
  parameter int W      = 16,
  parameter bit RIPPLE = 1'b0
) (
  input  logic [W-1:0] m_i,
  input  logic [W-1:0] n_i,
  input  logic         cin_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] res_o,
  output logic         zero_o,
  output logic         neg_o
);

  alu_op_e      op;
  logic [W-1:0] adder_b;
  logic         adder_ci;
  logic         is_arith;
  logic [W-1:0] add_sum;
  logic [W-1:0] logic_res;

  assign op = alu_op_e'(op_i);

  alu16_operand_mux #(.W(W)) u_opmux (
    .op(op), .m(m_i), .n(n_i), .cin(cin_i),
    .add_b(adder_b), .add_ci(adder_ci), .is_arith(is_arith)
  );

  alu16_shared_adder #(.W(W), .RIPPLE(RIPPLE)) u_adder (
    .a(m_i), .b(adder_b), .ci(adder_ci), .sum(add_sum)
  );

  alu16_logic_unit #(.W(W)) u_logic (
    .op(op), .m(m_i), .n(n_i), .out(logic_res)
  );

  assign res_o = is_arith ? add_sum : logic_res;

  alu16_flag_gen #(.W(W)) u_flags (
    .res(res_o), .zero(zero_o), .neg(neg_o)
  );

endmodule

// File: rtl/alu16_shared_chk.sv
module alu16_shared_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] m_i,
  input logic [W-1:0] n_i,
  input logic         cin_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] res_o,
  input logic         zero_o,
  input logic         neg_o,
  input logic [W-1:0] adder_b,
  input logic         adder_ci,
  input logic         is_arith
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic known;
  assign known = !$isunknown({m_i, n_i, cin_i, op_i});

  always_comb begin
    if (known) begin
      // R7
      zero_flag_chk: assert (zero_o == (res_o == '0));
      // R8
      neg_flag_chk: assert (neg_o == res_o[W-1]);
      // R6
      if (op_i == 3'b111) nop_result_chk: assert (res_o == '0);
      // R3
      if (op_i == 3'b010) inc_path_chk: assert (adder_b == '0 && adder_ci && res_o == m_i + ONE);
      // R9
      if (op_i == 3'b001 || op_i == 3'b011) cin_gate_chk: assert (!adder_ci);
      // R5
      if (op_i[2]) logic_route_chk: assert (!is_arith);
      // R1
      if (op_i == 3'b000) addc_path_chk: assert (adder_b == n_i && adder_ci == cin_i);
    end
  end

endmodule

bind alu16_shared alu16_shared_chk #(.W(W)) u_chk (
  .m_i(m_i), .n_i(n_i), .cin_i(cin_i), .op_i(op_i),
  .res_o(res_o), .zero_o(zero_o), .neg_o(neg_o),
  .adder_b(adder_b), .adder_ci(adder_ci), .is_arith(is_arith)
);

// File: tb/alu16_shared_tb_top.sv
module alu16_shared_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] m, n;
  logic        cin;
  logic [2:0]  op;
  logic [15:0] res;
  logic        zero, neg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  alu16_shared dut_i (
    .m_i(m), .n_i(n), .cin_i(cin), .op_i(op),
    .res_o(res), .zero_o(zero), .neg_o(neg)
  );

  typedef struct {
    logic [15:0] exp_res;
    string       tag;
  } item_t;

  item_t q[$];

  function automatic int floor_half(input int v);
    if (v >= 0) return v / 2;
    return -((-v + 1) / 2);
  endfunction

  function automatic logic [15:0] model(input logic [2:0] o, input logic [15:0] a,
                                        input logic [15:0] b, input logic c);
    int ai, bi, r;
    ai = int'($signed(a));
    bi = int'($signed(b));
    case (o)
      3'd0: r = ai + bi + int'(c);
      3'd1: r = ai + floor_half(bi);
      3'd2: r = ai + 1;
      3'd3: r = ai + floor_half(ai);
      3'd4: return a & b;
      3'd5: return a | b;
      3'd6: return ~a;
      default: return 16'h0000;
    endcase
    return r[15:0];
  endfunction

  function automatic string op_tag(input logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd7: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic drive(input logic [2:0] o, input logic [15:0] a, input logic [15:0] b,
                       input logic c, input string tag);
    item_t it;
    @(posedge clk);
    op = o; m = a; n = b; cin = c;
    it.exp_res = model(o, a, b, c);
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: combinational result due in the same cycle, sampled at the falling edge
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      item_t it;
      logic  ez, en;
      it = q.pop_front();
      ez = (it.exp_res == 16'h0000);
      en = it.exp_res[15];
      checks++;
      if (res !== it.exp_res) begin
        fails++;
        $display("FAIL %s op=%b m=%h n=%h cin=%b: res actual %h expected %h",
                 it.tag, op, m, n, cin, res, it.exp_res);
      end
      checks++;
      if (zero !== ez) begin
        fails++;
        $display("FAIL R7 (%s) zero actual %b expected %b", it.tag, zero, ez);
      end
      checks++;
      if (neg !== en) begin
        fails++;
        $display("FAIL R8 (%s) neg actual %b expected %b", it.tag, neg, en);
      end
    end
  end

  initial begin
    m = '0; n = '0; cin = 1'b0; op = 3'd0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // initial state: all-zero inputs give zero result, zero flag set (R1, R7)
    drive(3'd0, 16'h0000, 16'h0000, 1'b0, "R1 reset");
    // R1 carry and wrap
    drive(3'd0, 16'h1234, 16'h0001, 1'b1, "R1");
    drive(3'd0, 16'h7FFF, 16'h0000, 1'b1, "R1 wrap");
    drive(3'd0, 16'hFFFF, 16'h0001, 1'b0, "R1 zero");
    // R2 floor halving
    drive(3'd1, 16'h0010, 16'hFFFF, 1'b0, "R2 n=-1");
    drive(3'd1, 16'h0000, 16'hFFFD, 1'b0, "R2 n=-3");
    drive(3'd1, 16'h0003, 16'h0005, 1'b0, "R2 n=5");
    // R3 increment and wrap
    drive(3'd2, 16'h7FFF, 16'h5555, 1'b0, "R3");
    drive(3'd2, 16'hFFFF, 16'h0000, 1'b0, "R3 wrap");
    // R4 scale by 1.5
    drive(3'd3, 16'hFFFD, 16'h0000, 1'b0, "R4 m=-3");
    drive(3'd3, 16'h0007, 16'h0000, 1'b0, "R4 m=7");
    drive(3'd3, 16'h6000, 16'h0000, 1'b0, "R4 wrap");
    // R5 logic
    drive(3'd4, 16'hF0F0, 16'h3C3C, 1'b0, "R5 and");
    drive(3'd5, 16'hF0F0, 16'h0F0F, 1'b0, "R5 or");
    drive(3'd6, 16'h00FF, 16'hAAAA, 1'b0, "R5 not");
    drive(3'd6, 16'h00FF, 16'h5555, 1'b1, "R5 not n-indep");
    drive(3'd6, 16'hFFFF, 16'h1234, 1'b0, "R5 not zero");
    // R6 nop
    drive(3'd7, 16'hFFFF, 16'hFFFF, 1'b1, "R6");
    drive(3'd7, 16'h8000, 16'h1234, 1'b0, "R6");
    // R9 carry ignored outside code 000
    for (int o = 1; o < 8; o++) begin
      drive(3'(o), 16'h8421, 16'h1357, 1'b0, "R9 cin=0");
      drive(3'(o), 16'h8421, 16'h1357, 1'b1, "R9 cin=1");
    end
    // randomized operands against the model
    for (int k = 0; k < 400; k++) begin
      logic [2:0] ro;
      ro = 3'($urandom_range(0, 7));
      drive(ro, 16'($urandom), 16'($urandom), 1'($urandom), op_tag(ro));
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule